// File: doc/BRIEF.md
# Packetised Stream to I2S Serialiser

The block takes stereo audio from an AXI4-Stream slave port. Traffic arrives in packets. Each packet opens with a fixed number of header beats, from zero to three, and the rest are sample beats. A position counter marks the header beats, which are accepted and thrown away. The sample beats go into a FIFO of 2^ADDR_W entries. An I2S shifter drains the FIFO one stereo pair per frame and sends each channel as a CHAN_W-bit word, most significant bit first.

Each beat carries a left sample in the upper SAMP_W bits of the data and a right sample in the lower SAMP_W bits. A sample sits at the top of its channel word, and the spare low bits are sent as zeros. A parameter picks the clocking role:
- **Master:** the block divides the system clock to make the bit clock and makes word select itself.
- **Slave:** the block synchronises an external bit clock and word select and follows them.

When the FIFO is empty at the start of a frame, the block sends zero words and sets a sticky underflow flag.

Top module: `stream_i2s_tx`

## Requirements
- R1: The first HDR_WORDS beats of each packet are accepted and discarded, and never appear on sd_o.
- R2: The packet position returns to zero after a beat with s_tlast high, or after HDR_WORDS+PKT_SAMPLES beats, whichever comes first. A short packet is therefore followed by a correctly stripped next packet.
- R3: s_tready is high on every header beat, even while the FIFO is full.
- R4: On a sample beat, s_tready is low while the FIFO holds 2^ADDR_W pairs.
- R5: Pairs leave in arrival order. s_tdata bits [2*SAMP_W-1:SAMP_W] form the left sample and bits [SAMP_W-1:0] the right sample. Each channel word is CHAN_W bits: the sample in the top SAMP_W bits, zeros below, sent MSB first.
- R6: ws_o low marks the left word and high the right word. The MSB is sent one bit clock after the word-select change. sd_o changes only while bclk_o is low, after a falling edge.
- R7: In master mode, bclk_o has a period of 2*BCLK_DIV system clocks. ws_o toggles every CHAN_W bit clocks, on a falling bclk_o edge.
- R8: In slave mode, bit clock and word select are taken from bclk_in and ws_in through two-stage synchronisers. The serial data follows that external framing.
- R9: If the FIFO is empty when a left word is due, both words of that frame are zero and underflow_o goes high and stays high until reset.
- R10: After reset, s_tready is 1 and underflow_o, ws_o and sd_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tdata | input | 2*SAMP_W | Left sample (upper) and right sample (lower) |
| s_tlast | input | 1 | Last beat of packet |
| bclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| bclk_o | output | 1 | Bit clock in use |
| ws_o | output | 1 | Word select in use |
| sd_o | output | 1 | Serial data |
| underflow_o | output | 1 | Sticky FIFO underflow flag |

## Verification
Two things can fall in one clock cycle: a FIFO write from the stream and a FIFO read at the start of a left word. The FIFO's occupancy must update correctly when both happen at once.

The bench provokes this by keeping the stream valid at all times, so the FIFO sits full and stalls the stream. Each frame's read then frees a slot, and a stalled sample beat is written in the cycle right after the read. One cycle later, the next sample beat is presented while the FIFO is one short of full.

The scoreboard judges the result by decoding sd_o at every rising bclk_o. Every sample must come out exactly once, in order, in its own channel. Header beats presented while the FIFO is full must pass without a stall.

// File: rtl/stream_i2s_tx.sv
module stream_i2s_tx #(
  parameter int CHAN_W      = 16,
  parameter int SAMP_W      = 12,
  parameter int ADDR_W      = 3,
  parameter int PKT_SAMPLES = 4,
  parameter int HDR_WORDS   = 2,
  parameter bit MASTER      = 1'b1,
  parameter int BCLK_DIV    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_tvalid,
  output logic                s_tready,
  input  logic [2*SAMP_W-1:0] s_tdata,
  input  logic                s_tlast,
  input  logic                bclk_in,
  input  logic                ws_in,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underflow_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = $clog2(HDR_WORDS + PKT_SAMPLES + 1);
  localparam int DW    = $clog2(BCLK_DIV + 1);
  localparam int BW    = $clog2(CHAN_W);

  logic [PW-1:0]       pos;
  logic [2*SAMP_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]   wptr, rptr;
  logic [ADDR_W:0]     cnt;
  logic [DW-1:0]       div_cnt;
  logic [BW-1:0]       bit_cnt;
  logic                bclk_r, ws_r;
  logic [1:0]          bsync, wsync;
  logic                bc, ws_v, bc_q, ws_seen, sd_r, uf_r;
  logic [CHAN_W-1:0]   sh, hold, left_w, right_w;

  wire is_hdr = pos < PW'(HDR_WORDS);
  wire full   = cnt == (ADDR_W+1)'(DEPTH);
  wire empty  = cnt == '0;
  assign s_tready = is_hdr || !full;
  wire accept = s_tvalid && s_tready;
  wire push   = accept && !is_hdr;
  wire at_end = pos == PW'(HDR_WORDS + PKT_SAMPLES - 1);

  assign bc   = MASTER ? bclk_r : bsync[1];
  assign ws_v = MASTER ? ws_r   : wsync[1];
  wire fall   = bc_q && !bc;
  wire wsedge = fall && (ws_v != ws_seen);
  wire pop    = wsedge && !ws_v && !empty;

  always_comb begin
    left_w  = '0;
    right_w = '0;
    left_w[CHAN_W-1 -: SAMP_W]  = mem[rptr][2*SAMP_W-1:SAMP_W];
    right_w[CHAN_W-1 -: SAMP_W] = mem[rptr][SAMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (accept) pos <= (s_tlast || at_end) ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk) if (push) mem[wptr] <= s_tdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + (ADDR_W+1)'(push) - (ADDR_W+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0; bclk_r <= 1'b0; ws_r <= 1'b0; bit_cnt <= '0;
    end else if (div_cnt == DW'(BCLK_DIV - 1)) begin
      div_cnt <= '0;
      bclk_r  <= ~bclk_r;
      if (bclk_r) begin
        if (bit_cnt == BW'(CHAN_W - 1)) begin
          bit_cnt <= '0;
          ws_r    <= ~ws_r;
        end else bit_cnt <= bit_cnt + 1'b1;
      end
    end else div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bsync <= '0; wsync <= '0;
    end else begin
      bsync <= {bsync[0], bclk_in};
      wsync <= {wsync[0], ws_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_q <= 1'b0; ws_seen <= 1'b0; sd_r <= 1'b0; uf_r <= 1'b0;
      sh <= '0; hold <= '0;
    end else begin
      bc_q <= bc;
      if (fall) begin
        ws_seen <= ws_v;
        sd_r    <= sh[CHAN_W-1];
        if (wsedge) begin
          if (ws_v) sh <= hold;
          else if (!empty) begin
            sh   <= left_w;
            hold <= right_w;
          end else begin
            sh   <= '0;
            hold <= '0;
            uf_r <= 1'b1;
          end
        end else sh <= {sh[CHAN_W-2:0], 1'b0};
      end
    end
  end

  assign bclk_o      = bc;
  assign ws_o        = ws_v;
  assign sd_o        = sd_r;
  assign underflow_o = uf_r;

  // R4
  fifo_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= (ADDR_W+1)'(DEPTH));
  // R3
  hdr_take_chk: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && pos < PW'(HDR_WORDS)) |-> s_tready);
  // R9
  uf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_o |=> underflow_o);
  // R6
  sd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(sd_o));

  if (MASTER) begin : g_mchk
    // R7
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (ws_o != $past(ws_o)) |-> $fell(bclk_o));
  end
endmodule

// File: tb/stream_i2s_tx_test.sv
module stream_i2s_tx_test;
  localparam int CW = 16, SW = 12, AW = 3, PK = 4, HD = 2, DIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic          tvalid = 0, tlast = 0, tready, bclk, ws, sd, uf;
  logic [2*SW-1:0] tdata = '0;
  logic          s_tvalid = 0, s_tlast = 0, s_tready, s_bclk, s_ws, s_sd, s_uf;
  logic [2*SW-1:0] s_tdata = '0;

  stream_i2s_tx #(.CHAN_W(CW), .SAMP_W(SW), .ADDR_W(AW), .PKT_SAMPLES(PK),
    .HDR_WORDS(HD), .MASTER(1'b1), .BCLK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .s_tvalid(tvalid), .s_tready(tready), .s_tdata(tdata),
    .s_tlast(tlast), .bclk_in(1'b0), .ws_in(1'b0), .bclk_o(bclk), .ws_o(ws),
    .sd_o(sd), .underflow_o(uf));

  stream_i2s_tx #(.CHAN_W(CW), .SAMP_W(SW), .ADDR_W(AW), .PKT_SAMPLES(PK),
    .HDR_WORDS(HD), .MASTER(1'b0), .BCLK_DIV(DIV)) uut_s (
    .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tlast(s_tlast), .bclk_in(bclk), .ws_in(ws), .bclk_o(s_bclk), .ws_o(s_ws),
    .sd_o(s_sd), .underflow_o(s_uf));

  int checks = 0, fails = 0;
  logic [CW:0] expq[$], sexpq[$];
  logic drv_done = 0, s_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cword(input logic [SW-1:0] s);
    logic [CW-1:0] w;
    w = '0;
    w[CW-1 -: SW] = s;
    return w;
  endfunction

  task automatic beat(input logic [2*SW-1:0] d, input logic l, input bit hdr, output int waits);
    tdata = d; tlast = l; tvalid = 1'b1; waits = 0;
    #1;
    while (!tready) begin waits++; @(negedge clk); #1; end
    @(negedge clk);
    tvalid = 1'b0; tlast = 1'b0;
    if (!hdr) begin
      expq.push_back({1'b0, cword(d[2*SW-1:SW])});
      expq.push_back({1'b1, cword(d[SW-1:0])});
    end
  endtask

  task automatic pkt(input int n, input int base, input bit use_last, input bit hdr_full, input bit data_full);
    int w;
    for (int h = 0; h < HD; h++) begin
      beat(24'hDEA000 | 24'(base * 4 + h), 1'b0, 1'b1, w);
      // R3: header beat taken with no stall even while FIFO is full
      if (hdr_full) chk(w == 0, "R3 header stalled", 32'(w), 0);
    end
    for (int i = 0; i < n; i++) begin
      logic [SW-1:0] l, r;
      l = SW'(base * 64 + i * 7 + 1);
      r = SW'(12'hF0F ^ (l * 5));
      beat({l, r}, use_last && (i == n - 1), 1'b0, w);
      // R4: sample beat stalls while FIFO full
      if (data_full && i == 0) chk(w > 0, "R4 no stall when full", 32'(w), 1);
    end
  endtask

  task automatic sbeat(input logic [2*SW-1:0] d, input logic l, input bit hdr);
    s_tdata = d; s_tlast = l; s_tvalid = 1'b1;
    #1;
    while (!s_tready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    if (!hdr) begin
      sexpq.push_back({1'b0, cword(d[2*SW-1:SW])});
      sexpq.push_back({1'b1, cword(d[SW-1:0])});
    end
  endtask

  // master-side monitor
  logic pb = 0, pw = 0, psd = 0;
  logic [CW-1:0] acc = '0;
  logic [CW:0] item;
  int nr = 0, seg = 0, lastrise = 0, cyc = 0, badper = 0, badseg = 0, badsd = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sd != psd && bclk) badsd++;
      psd = sd;
      if (bclk && !pb) begin
        if (lastrise != 0 && cyc - lastrise != 2 * DIV) badper++;
        lastrise = cyc;
        acc = {acc[CW-2:0], sd};
        nr++;
        if (ws != pw) begin
          if (seg > 0 && nr != CW) badseg++;
          seg++;
          nr = 0;
          if (expq.size() > 0) begin
            item = expq.pop_front();
            // R1 R2 R5 R6 R9: decoded word/channel matches scoreboard
            chk({pw, acc} == item, "R5 word", 32'({pw, acc}), 32'(item));
          end
        end
        pw = ws;
      end
      pb = bclk;
    end
  end

  // slave-side monitor, framing taken from the master outputs
  logic pb2 = 0, pw2 = 0;
  logic [CW-1:0] acc2 = '0;
  logic [CW:0] item2;
  always @(negedge clk) begin
    if (!rst) begin
      if (bclk && !pb2) begin
        acc2 = {acc2[CW-2:0], s_sd};
        if (ws != pw2 && sexpq.size() > 0) begin
          item2 = sexpq.pop_front();
          // R8: slave follows external framing
          chk({pw2, acc2} == item2, "R8 slave word", 32'({pw2, acc2}), 32'(item2));
        end
        pw2 = ws;
      end
      pb2 = bclk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10
    chk(tready == 1'b1, "R10 tready", 32'(tready), 1);
    chk(uf == 1'b0, "R10 underflow", 32'(uf), 0);
    chk(ws == 1'b0, "R10 ws", 32'(ws), 0);
    chk(sd == 1'b0, "R10 sd", 32'(sd), 0);
    expq.push_back('0); expq.push_back({1'b1, {CW{1'b0}}});
    sexpq.push_back('0); sexpq.push_back({1'b1, {CW{1'b0}}});
    @(negedge clk);
    fork
      begin
        pkt(PK, 1, 1'b1, 1'b0, 1'b0);
        pkt(PK, 2, 1'b1, 1'b0, 1'b0);
        pkt(PK, 3, 1'b1, 1'b1, 1'b1);   // R3 R4: FIFO full here
        pkt(2,  4, 1'b1, 1'b0, 1'b0);   // R2: short packet ends on tlast
        pkt(PK, 5, 1'b0, 1'b0, 1'b0);   // R2: wraps without tlast
        pkt(PK, 6, 1'b1, 1'b0, 1'b0);
        // R9: no underflow while data kept flowing
        chk(uf == 1'b0, "R9 early underflow", 32'(uf), 0);
        for (int k = 0; k < 2; k++) begin
          expq.push_back('0);
          expq.push_back({1'b1, {CW{1'b0}}});
        end
        drv_done = 1'b1;
      end
      begin
        for (int h = 0; h < HD; h++) sbeat(24'hBAD000 | 24'(h), 1'b0, 1'b1);
        for (int i = 0; i < PK; i++) sbeat({SW'(12'h5A0 + i), SW'(12'h0C3 + 3 * i)}, i == PK - 1, 1'b0);
        sexpq.push_back('0);
        sexpq.push_back({1'b1, {CW{1'b0}}});
        s_done = 1'b1;
      end
    join
    wait (drv_done && s_done && expq.size() == 0 && sexpq.size() == 0);
    repeat (4) @(negedge clk);
    // R7: bit clock period and word-select spacing
    chk(badper == 0, "R7 bclk period", 32'(badper), 0);
    chk(badseg == 0, "R7 ws spacing", 32'(badseg), 0);
    chk(seg > 10, "R7 ws toggles", 32'(seg), 11);
    // R6: sd only moves while bclk is low
    chk(badsd == 0, "R6 sd timing", 32'(badsd), 0);
    // R9: sticky flag after drain
    chk(uf == 1'b1, "R9 underflow flag", 32'(uf), 1);
    repeat (3 * 2 * DIV * CW) @(negedge clk);
    chk(uf == 1'b1, "R9 underflow sticky", 32'(uf), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule